// File: doc/BRIEF.md
# Receive FIFO Pause Frame Trigger

This block watches how many bytes sit in a receive FIFO and decides when the MAC transmit path has to send flow-control pause frames. When the occupancy climbs above a high-water mark it asks for a frame that stops the link partner (XOFF). That frame carries a programmed pause time. When the occupancy later drains below a low-water mark it asks for a frame that releases the partner (XON). That frame carries a pause time of zero. The two marks are separate, so the gap between them gives hysteresis.

Both marks are 9-bit fields of one configuration word and count in units of 64 bytes. A low-water value of zero has a special meaning: the release frame is requested only when the FIFO is completely empty. A one-bit flow state (flowing or held) makes sure that requests follow state changes and nothing else. A request stays up until the frame sender acknowledges it. A newer state change overwrites a request that has not yet been taken. Building the frame, the FIFO storage and the MAC are outside this block.

Top module: `fifo_pause_trigger`

## Requirements
- R1: While `rst` is high, and after it, until a threshold is crossed, `pause_req` is 0, `pause_quanta` is 0 and the flow state is flowing.
- R2: The XOFF threshold is `thr_cfg[8:0]` and the XON threshold is `thr_cfg[20:12]`. Each counts units of 64 bytes. A field value above 0x6F acts as 0x6F. All other bits of `thr_cfg` have no effect.
- R3: In the flowing state, an occupancy strictly greater than XOFF×64 at a clock edge moves the block to held and raises `pause_req` after that edge. An occupancy equal to XOFF×64 raises nothing.
- R4: An XOFF request drives `pause_quanta` with the value of `pause_time_cfg` sampled at the edge that raised the request.
- R5: In the held state, with a non-zero XON threshold, an occupancy strictly less than XON×64 moves the block to flowing and raises a request with `pause_quanta` = 0. With an XON threshold of 0 this happens only at occupancy 0.
- R6: A raised request stays high until `snd_ack` is sampled high at a clock edge. After that edge it is low, unless a new request is raised at the same edge.
- R7: A request is raised only when the flow state changes. There is at most one XON per XOFF, and no request is raised while the occupancy stays on one side of the thresholds.
- R8: If the opposite state change comes due while a request is still pending, the pending request is replaced. `pause_req` stays high and `pause_quanta` takes the new value.
- R9: If a new request is raised at the same edge at which `snd_ack` is high, the new request wins and `pause_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_bytes | input | OCC_W (14) | Current receive FIFO occupancy in bytes |
| thr_cfg | input | CFG_W (32) | Threshold word: XOFF at [8:0], XON at [20:12] |
| pause_time_cfg | input | PT_W (16) | Pause time carried by XOFF frames |
| snd_ack | input | 1 | Frame sender has taken the pending request |
| pause_req | output | 1 | Pause frame requested |
| pause_quanta | output | PT_W (16) | Pause time for the requested frame (0 for XON) |

## Verification
The cases that are hardest to reach from the ports are the replacement of a request that has not been taken, and a new state change landing in the same cycle as an acknowledge. Both need the occupancy to cross the whole hysteresis band while the acknowledge is held back or timed exactly. The bench drives these two cases directly. It also sweeps rising and falling occupancy ramps over many threshold pairs, including over-range fields and set unused bits, with the acknowledge given only every third cycle. In this way pending requests are overtaken over and over, and each cycle is checked against an arithmetic model.

// File: rtl/pft_pkg.sv
package pft_pkg;
    localparam int THR_W       = 9;
    localparam int XOFF_LSB    = 0;
    localparam int XON_LSB     = 12;
    localparam int QUANT_SHIFT = 6;
    localparam int LIM_W       = THR_W + QUANT_SHIFT;
    localparam logic [THR_W-1:0] THR_MAX = 9'h06F;

    typedef enum logic {
        ST_FLOWING = 1'b0,
        ST_HELD    = 1'b1
    } flow_st_e;

    typedef struct packed {
        logic above_hi;
        logic below_lo;
    } level_t;

    function automatic logic [THR_W-1:0] clamp_thr(input logic [THR_W-1:0] v);
        return (v > THR_MAX) ? THR_MAX : v;
    endfunction
endpackage

// File: rtl/pft_thr_decode.sv
module pft_thr_decode
    import pft_pkg::*;
(
    input  logic [THR_W-1:0] field,
    output logic [LIM_W-1:0] limit_bytes
);
    logic [THR_W-1:0] clamped;

    always_comb begin
        clamped     = clamp_thr(field);
        limit_bytes = {clamped, {QUANT_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/pft_level_cmp.sv
module pft_level_cmp
    import pft_pkg::*;
#(
    parameter int OCC_W = 14
) (
    input  logic [OCC_W-1:0] occ,
    input  logic [LIM_W-1:0] hi_lim,
    input  logic [LIM_W-1:0] lo_lim,
    output level_t           lvl
);
    localparam int CW = (OCC_W > LIM_W) ? OCC_W : LIM_W;

    logic [CW-1:0] occ_x;
    logic [CW-1:0] hi_x;
    logic [CW-1:0] lo_x;

    always_comb begin
        occ_x = CW'(occ);
        hi_x  = CW'(hi_lim);
        lo_x  = CW'(lo_lim);
        lvl.above_hi = occ_x > hi_x;
        if (lo_x == '0) begin
            lvl.below_lo = (occ_x == '0);
        end else begin
            lvl.below_lo = occ_x < lo_x;
        end
    end
endmodule

// File: rtl/pft_req_ctrl.sv
module pft_req_ctrl
    import pft_pkg::*;
#(
    parameter int PT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  level_t          lvl,
    input  logic [PT_W-1:0] ptime,
    input  logic            ack,
    output logic            req,
    output logic [PT_W-1:0] quanta,
    output flow_st_e        state
);
    logic go_hold;
    logic go_flow;

    always_comb begin
        go_hold = (state == ST_FLOWING) && lvl.above_hi;
        go_flow = (state == ST_HELD) && lvl.below_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FLOWING;
            req    <= 1'b0;
            quanta <= '0;
        end else if (go_hold) begin
            state  <= ST_HELD;
            req    <= 1'b1;
            quanta <= ptime;
        end else if (go_flow) begin
            state  <= ST_FLOWING;
            req    <= 1'b1;
            quanta <= '0;
        end else if (ack) begin
            req    <= 1'b0;
        end
    end
endmodule

// File: rtl/fifo_pause_trigger.sv
module fifo_pause_trigger
    import pft_pkg::*;
#(
    parameter int OCC_W = 14,
    parameter int CFG_W = 32,
    parameter int PT_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ_bytes,
    input  logic [CFG_W-1:0] thr_cfg,
    input  logic [PT_W-1:0]  pause_time_cfg,
    input  logic             snd_ack,
    output logic             pause_req,
    output logic [PT_W-1:0]  pause_quanta
);
    localparam int NUM_THR = 2;
    localparam logic [CFG_W-1:0] FIELD_ONES = CFG_W'((1 << THR_W) - 1);
    localparam logic [CFG_W-1:0] USED_MASK  =
        (FIELD_ONES << XOFF_LSB) | (FIELD_ONES << XON_LSB);

    logic [LIM_W-1:0] lim [NUM_THR];
    level_t           lvl;
    flow_st_e         flow_state;
    logic             paused_q;
    logic             unused_cfg;

    assign unused_cfg = ^(thr_cfg & ~USED_MASK);

    // index 0: high-water (XOFF) field, index 1: low-water (XON) field
    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        localparam int FLD_LSB = (g == 0) ? XOFF_LSB : XON_LSB;
        pft_thr_decode u_dec (
            .field      (thr_cfg[FLD_LSB +: THR_W]),
            .limit_bytes(lim[g])
        );
    end

    pft_level_cmp #(.OCC_W(OCC_W)) u_cmp (
        .occ   (occ_bytes),
        .hi_lim(lim[0]),
        .lo_lim(lim[1]),
        .lvl   (lvl)
    );

    pft_req_ctrl #(.PT_W(PT_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl),
        .ptime (pause_time_cfg),
        .ack   (snd_ack),
        .req   (pause_req),
        .quanta(pause_quanta),
        .state (flow_state)
    );

    assign paused_q = (flow_state == ST_HELD);
endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
    parameter int PT_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            snd_ack,
    input logic [PT_W-1:0] pause_time_cfg,
    input logic            pause_req,
    input logic [PT_W-1:0] pause_quanta,
    input logic            paused
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R6: an unacknowledged request is never dropped
    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !snd_ack) |=> pause_req);

    // R5: a release request always carries zero pause time
    assert_xon_zero_time_R5: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !paused) |-> (pause_quanta == '0));

    // R4: the stop request carries the pause time present at its edge
    assert_xoff_time_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(paused)) |-> (pause_quanta == $past(pause_time_cfg)));

    // R7: every flow state change comes with a request
    assert_change_has_req_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (paused != $past(paused))) |-> pause_req);

    // R7: a request only rises on a flow state change
    assert_no_dup_req_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(pause_req)) |-> (paused != $past(paused)));
endmodule

bind fifo_pause_trigger pft_checker #(.PT_W(PT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .snd_ack       (snd_ack),
    .pause_time_cfg(pause_time_cfg),
    .pause_req     (pause_req),
    .pause_quanta  (pause_quanta),
    .paused        (paused_q)
);

// File: tb/fifo_pause_trigger_tb.sv
module fifo_pause_trigger_tb;
    localparam int OCC_W = 14;
    localparam int CFG_W = 32;
    localparam int PT_W  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [OCC_W-1:0] occ = '0;
    logic [CFG_W-1:0] cfg = 32'h0000_0078;
    logic [PT_W-1:0]  ptime = 16'h1234;
    logic             ack = 1'b0;
    logic             req;
    logic [PT_W-1:0]  quanta;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    fifo_pause_trigger #(.OCC_W(OCC_W), .CFG_W(CFG_W), .PT_W(PT_W)) u_dut (
        .clk(clk), .rst(rst), .occ_bytes(occ), .thr_cfg(cfg),
        .pause_time_cfg(ptime), .snd_ack(ack),
        .pause_req(req), .pause_quanta(quanta)
    );

    // arithmetic model built from the requirements
    logic            m_held  = 1'b0;
    logic            m_req   = 1'b0;
    logic [PT_W-1:0] m_q     = '0;

    function automatic int lim_of(input int fld);
        int c;
        c = (fld > 'h6F) ? 'h6F : fld;
        return c * 64;
    endfunction

    always @(posedge clk) begin
        int hi;
        int lo;
        bit above;
        bit below;
        hi = lim_of(int'(cfg[8:0]));
        lo = lim_of(int'(cfg[20:12]));
        above = int'(occ) > hi;
        below = (lo == 0) ? (occ == 0) : (int'(occ) < lo);
        if (rst) begin
            m_held <= 1'b0; m_req <= 1'b0; m_q <= '0;
        end else if (!m_held && above) begin
            m_held <= 1'b1; m_req <= 1'b1; m_q <= ptime;
        end else if (m_held && below) begin
            m_held <= 1'b0; m_req <= 1'b1; m_q <= '0;
        end else if (ack) begin
            m_req <= 1'b0;
        end
    end

    task automatic expect_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int o, input bit a, input string tag);
        @(negedge clk);
        occ = OCC_W'(o);
        ack = a;
        @(posedge clk);
        #1;
        expect_eq({tag, " req vs model"}, int'(req), int'(m_req));
        expect_eq({tag, " quanta vs model"}, int'(quanta), int'(m_q));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        expect_eq("R1 req in reset", int'(req), 0);
        expect_eq("R1 quanta in reset", int'(quanta), 0);
        @(negedge clk);
        rst = 1'b0;
        cyc(500, 0, "R1");
        expect_eq("R1 idle after reset", int'(req), 0);

        // R2 clamp of default field 0x78 -> 0x6F*64 = 7104; R3 equality boundary
        cyc(7104, 0, "R3");
        expect_eq("R3 equal does not trigger", int'(req), 0);
        ptime = 16'hBEEF;
        cyc(7105, 0, "R2");
        expect_eq("R2 clamped XOFF raised", int'(req), 1);
        expect_eq("R4 XOFF time", int'(quanta), 'hBEEF);
        ptime = 16'h0101;
        cyc(7105, 0, "R6");
        expect_eq("R6 held without ack", int'(req), 1);
        expect_eq("R4 time latched", int'(quanta), 'hBEEF);
        cyc(7105, 1, "R6");
        expect_eq("R6 dropped after ack", int'(req), 0);
        for (int i = 0; i < 5; i++) cyc(9000, 0, "R7");
        expect_eq("R7 no duplicate XOFF", int'(req), 0);

        // R5 XON threshold zero: only at empty
        cyc(1, 0, "R5");
        expect_eq("R5 zero thr, occ 1 no XON", int'(req), 0);
        cyc(0, 0, "R5");
        expect_eq("R5 XON at empty", int'(req), 1);
        expect_eq("R5 XON time zero", int'(quanta), 0);
        cyc(0, 1, "R5");
        for (int i = 0; i < 4; i++) cyc(0, 0, "R7");
        expect_eq("R7 single XON", int'(req), 0);

        // R8 replacement both ways: XOFF 2 (128 B), XON 1 (64 B)
        cfg = 32'h0000_1002;
        ptime = 16'h00A5;
        cyc(200, 0, "R8");
        expect_eq("R8 XOFF pending", int'(quanta), 'hA5);
        cyc(10, 0, "R8");
        expect_eq("R8 XON replaces XOFF req", int'(req), 1);
        expect_eq("R8 XON replaces XOFF time", int'(quanta), 0);
        cyc(200, 0, "R8");
        expect_eq("R8 XOFF replaces XON", int'(quanta), 'hA5);

        // R9 new event in the ack cycle wins
        cyc(10, 1, "R9");
        expect_eq("R9 event beats ack", int'(req), 1);
        expect_eq("R9 XON time", int'(quanta), 0);
        cyc(10, 1, "R9");
        expect_eq("R9 ack then clears", int'(req), 0);
        cyc(64, 0, "R5");
        expect_eq("R5 equal XON limit no event", int'(req), 0);

        // R2/R3/R5/R8 sweep over threshold pairs, unused bits set
        for (int xi = 0; xi < 7; xi++) begin
            for (int yi = 0; yi < 3; yi++) begin
                int xf;
                int yf;
                int step;
                xf = (xi == 0) ? 0 : (xi == 1) ? 1 : (xi == 2) ? 2 : (xi == 3) ? 5 :
                     (xi == 4) ? 'h6F : (xi == 5) ? 'h70 : 'h1FF;
                yf = (yi == 0) ? 0 : (yi == 1) ? 1 : 3;
                cfg = 32'hFFE0_0E00 | CFG_W'(xf) | (CFG_W'(yf) << 12);
                ptime = PT_W'(16'h0100 + xi * 16 + yi);
                step = 0;
                for (int o = 0; o < 8000; o += 61) begin
                    cyc(o, (step % 3) == 0, "R2/R3 sweep up");
                    step++;
                end
                for (int o = 8000; o >= 0; o -= 53) begin
                    cyc(o, (step % 3) == 0, "R5/R8 sweep down");
                    step++;
                end
                cyc(0, 1, "R5 sweep empty");
                cyc(0, 1, "R6 sweep drain");
            end
        end

        finish_run();
    end
endmodule